// File: doc/BRIEF.md
# Glitch-Free Clock Output Gating Controller

This block takes one free-running output-domain clock and derives a set of gated copies from it, one per output lane. Each lane runs only when its board-level enable input and its configuration enable bit are both high. Every gate decision moves through a registered run stage and is applied on the falling clock edge. Because of this, an output can only start or stop between whole pulses and always rests low when stopped.

A single asynchronous control input has two meanings. After reset it acts as a power-good qualifier: while it stays low, all outputs are held off, but the configuration bits can still be written. The first time it is seen high, a sticky qualification state is entered. From then on a low level on the same input is a power-down request. It raises a registered power-down status, which shuts down the oscillator and configuration logic elsewhere. It also silences every output and freezes the configuration bits. Only the global reset returns the block to the unqualified state. All asynchronous inputs pass through two-flop synchronizers into the output clock domain.

Top module: `out_clk_gater`

## Requirements
- R1: After reset and before the control input has ever been sampled high, every output stays low and the power-down status stays low, whatever the enable inputs and configuration bits are.
- R2: Once the control input has been sampled high, a later low level raises the power-down status on the second rising edge after the edge that samples the low. The status falls again on the second rising edge after the edge that samples a high.
- R3: While power-down is in effect, all outputs are low. After the control input returns high, outputs resume in the clock-high phase that follows the third rising edge after the sampling edge (within the 2 to 6 cycle window).
- R4: Output i pulses in a clock-high phase only when enable input i and configuration bit i are both high. Either one low stops it.
- R5: A change on enable input i, sampled at rising edge k, first shows on output i in the high phase after rising edge k+3.
- R6: A configuration write taken at rising edge k first shows on the outputs in the high phase after rising edge k+2.
- R7: Every output is low whenever the source clock is low, and each high phase of an output is either a full source-clock high phase or absent.
- R8: Reset sets all configuration enable bits to one and clears the qualification state, so that a low control input after reset is again treated as not yet power-good.
- R9: A configuration write presented while the power-down status is high is ignored, and the bits keep their previous values.
- R10: Configuration write data bit i controls output i only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock of the output domain |
| rst | input | 1 | Synchronous active-high global reset |
| pwr_ctl_n | input | 1 | Asynchronous power-good qualifier, later an active-low power-down request |
| en_pin | input | N_OUT | Asynchronous per-output enable inputs |
| cfg_wr | input | 1 | Configuration enable write strobe |
| cfg_wdata | input | N_OUT | Configuration enable write data, bit i for output i |
| clk_out | output | N_OUT | Gated clock outputs |
| core_pd | output | 1 | Registered power-down status for oscillator and configuration logic |

## Verification
Directed sequences first hold the control input low after reset while the enables and configuration bits toggle. This separates the qualification phase from a real power-down. Single-bit steps on one enable input and one-hot configuration writes measure the exact restart latency and show that each bit reaches only its own lane. A power-down with a configuration write inside it, followed by a second reset, separates a frozen register from a reset register and shows that the sticky qualification is cleared. Long seeded random runs mix enable, write and power-control changes. They are compared, in each phase of every cycle, against a bench latency model, which exposes off-by-one latencies, wrong AND terms and truncated pulses.

// File: rtl/gater_pkg.sv
package gater_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    QS_WAIT   = 2'd0,
    QS_ACTIVE = 2'd1,
    QS_DOWN   = 2'd2
  } qual_state_t;
endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/pwr_qualifier.sv
module pwr_qualifier
  import gater_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pwr_sync,
  output logic qualified,
  output logic pd_status
);
  qual_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      QS_WAIT:   if (pwr_sync)  st_d = QS_ACTIVE;
      QS_ACTIVE: if (!pwr_sync) st_d = QS_DOWN;
      QS_DOWN:   if (pwr_sync)  st_d = QS_ACTIVE;
      default:                  st_d = QS_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= QS_WAIT;
    else     st_q <= st_d;
  end

  assign qualified = (st_q != QS_WAIT);
  assign pd_status = (st_q == QS_DOWN);
endmodule

// File: rtl/out_gate_cell.sv
module out_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic pin_ok,
  input  logic cfg_ok,
  input  logic pwr_ok,
  output logic clk_gated
);
  logic run_q;
  logic gate_q;

  // decision registered in the rising-edge domain
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= pin_ok & cfg_ok & pwr_ok;
  end

  // gate moves only while the clock is low
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= run_q;
  end

  assign clk_gated = clk & gate_q;
endmodule

// File: rtl/out_clk_gater.sv
module out_clk_gater
  import gater_pkg::*;
#(
  parameter int unsigned       N_OUT     = 6,
  parameter logic [N_OUT-1:0]  CFG_RESET = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_ctl_n,
  input  logic [N_OUT-1:0] en_pin,
  input  logic             cfg_wr,
  input  logic [N_OUT-1:0] cfg_wdata,
  output logic [N_OUT-1:0] clk_out,
  output logic             core_pd
);
  localparam int unsigned SYNC_W = N_OUT + 1;

  logic [SYNC_W-1:0] sync_in, sync_out;
  logic [N_OUT-1:0]  pin_s;
  logic              pwr_s;
  logic              qualified;
  logic              pd_status;
  logic [N_OUT-1:0]  en_reg_q;

  assign sync_in = {pwr_ctl_n, en_pin};

  gate_sync #(.W(SYNC_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_in),
    .q   (sync_out)
  );

  assign pin_s = sync_out[N_OUT-1:0];
  assign pwr_s = sync_out[N_OUT];

  pwr_qualifier u_qual (
    .clk       (clk),
    .rst       (rst),
    .pwr_sync  (pwr_s),
    .qualified (qualified),
    .pd_status (pd_status)
  );

  // configuration enables; frozen while powered down
  always_ff @(posedge clk) begin
    if (rst)                        en_reg_q <= CFG_RESET;
    else if (cfg_wr && !pd_status)  en_reg_q <= cfg_wdata;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    out_gate_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .pin_ok    (pin_s[g]),
      .cfg_ok    (en_reg_q[g]),
      .pwr_ok    (pwr_s),
      .clk_gated (clk_out[g])
    );
  end

  assign core_pd = pd_status;
endmodule

// File: rtl/out_clk_gater_chk.sv
module out_clk_gater_chk #(
  parameter int unsigned N_OUT = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [N_OUT-1:0] clk_out,
  input logic             core_pd,
  input logic             qualified,
  input logic [N_OUT-1:0] en_reg_q
);
  AST_LOW_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst) clk_out == '0); // R7
  AST_STICKY_QUAL: assert property (@(posedge clk) disable iff (rst) qualified |=> qualified); // R2
  AST_PD_SILENT: assert property (@(negedge clk) disable iff (rst) $past(core_pd) |-> clk_out == '0); // R3
  AST_PREQUAL_SILENT: assert property (@(negedge clk) disable iff (rst) !$past(qualified) |-> clk_out == '0); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst) core_pd |=> $stable(en_reg_q)); // R9
endmodule

bind out_clk_gater out_clk_gater_chk #(.N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_out   (clk_out),
  .core_pd   (core_pd),
  .qualified (qualified),
  .en_reg_q  (en_reg_q)
);

// File: tb/test_out_clk_gater.sv
`timescale 1ns/1ps
module test_out_clk_gater;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pwr_ctl_n = 1'b0;
  logic [N-1:0] en_pin = '1;
  logic         cfg_wr = 1'b0;
  logic [N-1:0] cfg_wdata = '0;
  logic [N-1:0] clk_out;
  logic         core_pd;

  int    n_checks = 0;
  int    n_err = 0;
  bit    mon_on = 0;
  string cur_req = "R8";

  always #2.5 clk = ~clk;

  out_clk_gater #(.N_OUT(N)) i_out_clk_gater (
    .clk(clk), .rst(rst), .pwr_ctl_n(pwr_ctl_n), .en_pin(en_pin),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .clk_out(clk_out), .core_pd(core_pd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // latency model built from the requirement timings (R2, R5, R6)
  logic [N-1:0] pin_d1 = '0, pin_d2 = '0, run_m = '0, reg_m = '1, reg_n = '1, exp_gate = '0;
  logic pwr_d1 = 0, pwr_d2 = 0, qual_m = 0, pd_m = 0, pd_n = 0;

  always @(posedge clk) begin
    exp_gate = run_m;
    if (rst) begin
      pin_d1 = '0; pin_d2 = '0; run_m = '0; reg_m = '1;
      pwr_d1 = 0; pwr_d2 = 0; qual_m = 0; pd_m = 0;
    end else begin
      reg_n = (cfg_wr && !pd_m) ? cfg_wdata : reg_m;
      run_m = pin_d2 & reg_m & {N{pwr_d2}};
      pd_n  = qual_m & !pwr_d2;
      qual_m = qual_m | pwr_d2;
      pd_m  = pd_n;
      reg_m = reg_n;
      pin_d2 = pin_d1; pin_d1 = en_pin;
      pwr_d2 = pwr_d1; pwr_d1 = pwr_ctl_n;
    end
  end

  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      chk(clk_out == exp_gate, cur_req, clk_out, exp_gate);
      chk(core_pd == pd_m, cur_req, core_pd, pd_m);
    end
    #1.2;
    if (mon_on) chk(clk_out == exp_gate, "R7 full pulse", clk_out, exp_gate);
  end

  always @(negedge clk) begin
    #1;
    if (mon_on) chk(clk_out == '0, "R7 low phase", clk_out, 0);
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1.5; end
  endtask

  task automatic rand_run(input int n, input bit pwr_rand);
    repeat (n) begin
      @(negedge clk); #1.5;
      cfg_wr = 1'b0;
      if ($urandom_range(0, 3) == 0) en_pin = en_pin ^ N'(1 << $urandom_range(0, N-1));
      if ($urandom_range(0, 7) == 0) begin cfg_wr = 1'b1; cfg_wdata = N'($urandom); end
      if (pwr_rand && $urandom_range(0, 15) == 0) pwr_ctl_n = ~pwr_ctl_n;
    end
    @(negedge clk); #1.5; cfg_wr = 1'b0;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    int first;
    void'($urandom(32'd1357));
    cyc(4);
    chk(clk_out == '0, "R8 reset outputs", clk_out, 0);
    chk(core_pd == 1'b0, "R8 reset status", core_pd, 0);
    rst = 1'b0; mon_on = 1;

    // R1: control low from reset, enables and writes move
    cur_req = "R1";
    rand_run(40, 0);
    cfg_wr = 1'b1; cfg_wdata = '1; cyc(1); cfg_wr = 1'b0;
    en_pin = '1;
    cyc(4);

    // R3: qualify and start; R8: default bits all ones
    cur_req = "R3";
    pwr_ctl_n = 1'b1;
    cyc(8);
    chk(core_pd == 1'b0, "R8 running after qualify", core_pd, 0);

    // R5 directed latency on lane 0
    en_pin[0] = 1'b0; cyc(8);
    @(negedge clk); #1.5; en_pin[0] = 1'b1;
    first = 0;
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk); #1;
      if (clk_out[0] && first == 0) first = c;
    end
    chk(first == 4, "R5 restart edge", first, 4);

    // R6 directed write latency
    @(negedge clk); #1.5; cfg_wr = 1'b1; cfg_wdata = '0;
    cyc(6);
    @(negedge clk); #1.5; cfg_wr = 1'b1; cfg_wdata = '1;
    first = 0;
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk); #1;
      if (c == 1) cfg_wr = 1'b0;
      if (clk_out[1] && first == 0) first = c;
    end
    chk(first == 3, "R6 write edge", first, 3);

    // R10 one-hot configuration writes
    cur_req = "R10";
    for (int b = 0; b < N; b++) begin
      @(negedge clk); #1.5; cfg_wr = 1'b1; cfg_wdata = N'(1 << b);
      cyc(1); cfg_wr = 1'b0;
      cyc(4);
      @(posedge clk); #1;
      chk(clk_out == N'(1 << b), "R10 one-hot lane", clk_out, N'(1 << b));
    end

    // R4 random enables and writes
    cur_req = "R4";
    rand_run(400, 0);

    // R2 power-down entry timing
    cur_req = "R2";
    en_pin = '1; cfg_wr = 1'b1; cfg_wdata = '1; cyc(1); cfg_wr = 1'b0; cyc(6);
    @(negedge clk); #1.5; pwr_ctl_n = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1; chk(core_pd == 1'b0, "R2 second edge", core_pd, 0);
    @(posedge clk); #1; chk(core_pd == 1'b1, "R2 third edge", core_pd, 1);

    // R9 write while powered down is ignored
    cur_req = "R9";
    cyc(2);
    cfg_wr = 1'b1; cfg_wdata = '0; cyc(1); cfg_wr = 1'b0;
    cyc(3);
    cur_req = "R3";
    pwr_ctl_n = 1'b1;
    cyc(6);
    @(posedge clk); #1;
    chk(clk_out == '1, "R9 bits kept after power-down", clk_out, '1);

    // R8 reset clears qualification
    cur_req = "R8";
    @(negedge clk); #1.5; rst = 1'b1; cyc(3);
    rst = 1'b0; pwr_ctl_n = 1'b0;
    cyc(10);
    chk(core_pd == 1'b0, "R8 unqualified after reset", core_pd, 0);
    pwr_ctl_n = 1'b1; cyc(8);

    // mixed random with power toggles
    cur_req = "R3";
    rand_run(1200, 1);

    mon_on = 0;
    cyc(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule